// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block lets a clocked master read and write an asynchronous static RAM of 512K words by 16 bits. The host side takes a one-cycle request with a write flag, a word address, write data and a per-byte mask. It answers with a one-cycle done pulse. For reads, the returned word is valid during that pulse. The memory side drives the address, an active-low and an active-high chip enable, output enable, write enable and one active-low strobe per byte lane. It also drives a split data bus: data out, data in and a per-lane drive enable, for a tri-state pad outside the block.

All memory timing is met by counting whole clock cycles. The counts come from the clock period and the speed grade (fast or slow) when the design is elaborated. Between accesses the RAM is held in standby. After every read, a turnaround interval keeps the controller off the data bus while the RAM may still be driving it.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, host_ready is 1, host_done is 0, mem_ce_n is 1, mem_ce is 0, mem_oe_n is 1, mem_we_n is 1, mem_bs_n is 2'b11 and mem_dq_oe is 2'b00.
- R2: A read keeps both chip enables active, mem_we_n high and mem_oe_n low for exactly ceil(read_cycle_ns / period) clock cycles. read_cycle_ns is 55 for grade 0 and 70 for grade 1. The count is at least the output-enable access time (25 or 35 ns) in cycles. host_done rises one cycle after the read ends, and host_rdata then holds the addressed word.
- R3: A write holds mem_we_n low for exactly the larger of ceil(pulse_ns / period) and ceil(setup_ns / period) cycles. pulse_ns is 45 or 55 and setup_ns is 25 or 30. mem_oe_n stays high for the whole write. Address and write data stay stable while mem_we_n is low, and host_done rises when the pulse ends.
- R4: Mask bit 0 selects the lane of data bits 7:0 and strobe mem_bs_n[0]. Mask bit 1 selects bits 15:8 and mem_bs_n[1]. During an access, the strobe of an unselected lane stays high. That lane is never driven and never written. Its half of host_rdata reads as zero.
- R5: Whenever host_ready is 1, the RAM is in standby: mem_ce_n=1, mem_ce=0, mem_oe_n=1, mem_we_n=1 and mem_bs_n=2'b11.
- R6: mem_dq_oe is never set while mem_oe_n is low. The first write drive after a read begins at least ceil(release_ns / period) cycles after mem_oe_n rises, where release_ns is 20 (grade 0) or 25 (grade 1).
- R7: A request with both mask bits clear produces host_done on the next cycle and no memory cycle. The chip enable never becomes active and memory contents are unchanged.
- R8: host_done lasts one cycle per accepted request. A request presented while host_ready is 0 is ignored: it produces no done and no memory change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request, sampled only while host_ready is 1 |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 19 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Byte-lane select, bit 0 = low byte |
| host_ready | output | 1 | Controller idle and able to accept a request |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read data, valid with host_done after a read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 = low byte |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_in | input | 16 | Data from the pad |
| mem_dq_oe | output | 2 | Per-lane drive enable for mem_dq_out |

## Verification
Two events can land on the same clock edge. One is a new host request arriving while the sequencer is busy. The other is the end of a read, where the data capture, the output-enable release and the start of the turnaround all happen together. The bench raises a write request in the middle of a read and holds it across the following cycles. It then judges that exactly one done occurs, that the rejected write never reaches the memory, and that the read data is intact. A write issued directly after a read then checks that the first bus drive keeps the required gap from the output-enable release.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_TURN  = 2'd3
  } seq_state_t;

  // Whole cycles needed to cover a delay in nanoseconds, never less than one.
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period);
    int unsigned p;
    int unsigned c;
    p = (period == 0) ? 1 : period;
    c = (ns + p - 1) / p;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Grade 0 = fast part, any other value = slow part.
  function automatic int unsigned rd_cycle_ns(input int unsigned grade);
    return (grade == 0) ? 55 : 70;
  endfunction

  function automatic int unsigned oe_access_ns(input int unsigned grade);
    return (grade == 0) ? 25 : 35;
  endfunction

  function automatic int unsigned we_pulse_ns(input int unsigned grade);
    return (grade == 0) ? 45 : 55;
  endfunction

  function automatic int unsigned din_setup_ns(input int unsigned grade);
    return (grade == 0) ? 25 : 30;
  endfunction

  function automatic int unsigned release_ns(input int unsigned grade);
    return (grade == 0) ? 20 : 25;
  endfunction

  function automatic int unsigned rd_cycles(input int unsigned grade,
                                            input int unsigned period);
    return max2(ns_to_cycles(rd_cycle_ns(grade), period),
                ns_to_cycles(oe_access_ns(grade), period));
  endfunction

  function automatic int unsigned wp_cycles(input int unsigned grade,
                                            input int unsigned period);
    return max2(ns_to_cycles(we_pulse_ns(grade), period),
                ns_to_cycles(din_setup_ns(grade), period));
  endfunction

  function automatic int unsigned turn_cycles(input int unsigned grade,
                                              input int unsigned period);
    return ns_to_cycles(release_ns(grade), period);
  endfunction

endpackage

// File: rtl/sram_timer.sv
`timescale 1ns/1ps
module sram_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (load)       cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_C  = 14,
  parameter int unsigned WP_C  = 12,
  parameter int unsigned TN_C  = 5,
  parameter int          CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic host_wr,
  input  logic mask_any,
  output logic ready,
  output logic accept,
  output logic skip,
  output logic nxt_rd,
  output logic nxt_wr,
  output logic rd_last,
  output logic wr_last
);
  seq_state_t       state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  assign ready   = (state_q == ST_IDLE);
  assign accept  = ready & host_req & mask_any;
  assign skip    = ready & host_req & ~mask_any;
  assign rd_last = (state_q == ST_READ)  & tmr_zero;
  assign wr_last = (state_q == ST_WRITE) & tmr_zero;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        tmr_load = 1'b1;
        if (host_wr) begin
          state_d = ST_WRITE;
          tmr_val = CNT_W'(WP_C - 1);
        end else begin
          state_d = ST_READ;
          tmr_val = CNT_W'(RD_C - 1);
        end
      end
      ST_READ: if (tmr_zero) begin
        state_d  = ST_TURN;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TN_C - 1);
      end
      ST_WRITE: if (tmr_zero) state_d = ST_IDLE;
      ST_TURN:  if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign nxt_rd = (state_d == ST_READ);
  assign nxt_wr = (state_d == ST_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  sram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );
endmodule

// File: rtl/sram_lane_drv.sv
`timescale 1ns/1ps
module sram_lane_drv #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             nxt_rd,
  input  logic             nxt_wr,
  input  logic             rd_last,
  input  logic [LANES-1:0] host_mask,
  input  logic [DW-1:0]    host_wdata,
  input  logic [DW-1:0]    dq_in,
  output logic [LANES-1:0] bs_n,
  output logic [LANES-1:0] dq_oe,
  output logic [DW-1:0]    dq_out,
  output logic [DW-1:0]    rdata
);
  logic [LANES-1:0] mask_q;
  logic [LANES-1:0] mask_sel;
  logic [DW-1:0]    wdata_q;
  logic             busy_nxt;

  assign busy_nxt = nxt_rd | nxt_wr;
  assign mask_sel = accept ? host_mask : mask_q;
  assign dq_out   = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      mask_q  <= host_mask;
      wdata_q <= host_wdata;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic              strb_r;
    logic              drv_r;
    logic [LANE_W-1:0] rd_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        strb_r <= 1'b1;
        drv_r  <= 1'b0;
        rd_r   <= '0;
      end else begin
        strb_r <= ~(busy_nxt & mask_sel[g]);
        drv_r  <= nxt_wr & mask_sel[g];
        if (rd_last)
          rd_r <= mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign bs_n[g]                  = strb_r;
    assign dq_oe[g]                 = drv_r;
    assign rdata[g*LANE_W +: LANE_W] = rd_r;
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int          ADDR_W        = 19,
  parameter int          DATA_W        = 16,
  localparam int         LANES         = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_mask,
  output logic              host_ready,
  output logic              host_done,
  output logic [DATA_W-1:0] host_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bs_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [LANES-1:0]  mem_dq_oe
);
  localparam int unsigned RD_C  = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned WP_C  = wp_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned TN_C  = turn_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned MAX_C = max2(max2(RD_C, WP_C), TN_C);
  localparam int          CNT_W = $clog2(MAX_C + 1);

  // Named internal events, also observed by the bound checker.
  logic go_accept;
  logic go_skip;
  logic go_nxt_rd;
  logic go_nxt_wr;
  logic go_rd_last;
  logic go_wr_last;

  logic [ADDR_W-1:0] addr_q;
  logic              ce_n_q, ce_q, oe_n_q, we_n_q, done_q;

  sram_seq #(
    .RD_C  (RD_C),
    .WP_C  (WP_C),
    .TN_C  (TN_C),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_req (host_req),
    .host_wr  (host_wr),
    .mask_any (|host_mask),
    .ready    (host_ready),
    .accept   (go_accept),
    .skip     (go_skip),
    .nxt_rd   (go_nxt_rd),
    .nxt_wr   (go_nxt_wr),
    .rd_last  (go_rd_last),
    .wr_last  (go_wr_last)
  );

  sram_lane_drv #(
    .LANES  (LANES),
    .LANE_W (8)
  ) u_lanes (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (go_accept),
    .nxt_rd     (go_nxt_rd),
    .nxt_wr     (go_nxt_wr),
    .rd_last    (go_rd_last),
    .host_mask  (host_mask),
    .host_wdata (host_wdata),
    .dq_in      (mem_dq_in),
    .bs_n       (mem_bs_n),
    .dq_oe      (mem_dq_oe),
    .dq_out     (mem_dq_out),
    .rdata      (host_rdata)
  );

  // Control pins are registered from the next-state decode, so they switch
  // on the same edge as the sequencer and cannot glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_n_q <= 1'b1;
      ce_q   <= 1'b0;
      oe_n_q <= 1'b1;
      we_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      if (go_accept) addr_q <= host_addr;
      ce_n_q <= ~(go_nxt_rd | go_nxt_wr);
      ce_q   <= go_nxt_rd | go_nxt_wr;
      oe_n_q <= ~go_nxt_rd;
      we_n_q <= ~go_nxt_wr;
      done_q <= go_rd_last | go_wr_last | go_skip;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = ce_n_q;
  assign mem_ce    = ce_q;
  assign mem_oe_n  = oe_n_q;
  assign mem_we_n  = we_n_q;
  assign host_done = done_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
  import sram_ctl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SPEED_GRADE   = 0,
  parameter int          ADDR_W        = 19,
  parameter int          DATA_W        = 16,
  localparam int         LANES         = DATA_W / 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_ready,
  input logic              host_done,
  input logic              go_accept,
  input logic              go_skip,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_bs_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic [LANES-1:0]  mem_dq_oe
);
  localparam int unsigned RD_C = rd_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned WP_C = wp_cycles(SPEED_GRADE, CLK_PERIOD_NS);
  localparam int unsigned TN_C = turn_cycles(SPEED_GRADE, CLK_PERIOD_NS);

  logic [15:0] we_run, oe_run, since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_run   <= '0;
      oe_run   <= '0;
      since_oe <= 16'hFFFF;
    end else begin
      we_run   <= mem_we_n ? 16'd0 : we_run + 16'd1;
      oe_run   <= mem_oe_n ? 16'd0 : oe_run + 16'd1;
      since_oe <= !mem_oe_n ? 16'd0 :
                  (since_oe == 16'hFFFF) ? since_oe : since_oe + 16'd1;
    end
  end

  assert_idle_standby_R5: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && (&mem_bs_n)));

  assert_read_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (oe_run == 16'(RD_C)));

  assert_write_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 16'(WP_C)));

  assert_write_oe_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_write_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dq_out)));

  assert_no_drive_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_dq_oe == '0));

  assert_turn_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|mem_dq_oe) |-> (since_oe >= 16'(TN_C)));

  assert_skip_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    go_skip |=> (host_done && mem_ce_n));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go_accept |=> !host_done);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    assert_lane_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe[g] |-> !mem_bs_n[g]);
  end
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SPEED_GRADE   (SPEED_GRADE),
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_ready (host_ready),
  .host_done  (host_done),
  .go_accept  (go_accept),
  .go_skip    (go_skip),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_ce     (mem_ce),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_bs_n   (mem_bs_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
  // Fast grade at 4 ns: cycle counts restated from the requirements.
  localparam int PER   = 4;
  localparam int T_RD  = (55 + PER - 1) / PER;  // 14
  localparam int T_WP  = (45 + PER - 1) / PER;  // 12 (setup 25 ns is shorter)
  localparam int T_TRN = (20 + PER - 1) / PER;  // 5

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0;
  logic [18:0] host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [1:0]  host_mask = '0;
  logic        host_ready, host_done;
  logic [15:0] host_rdata;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n;
  logic [1:0]  mem_bs_n, mem_dq_oe;
  logic [15:0] mem_dq_out, mem_dq_in;

  always #2 clk = ~clk;

  sram_lane_ctrl #(.CLK_PERIOD_NS(PER), .SPEED_GRADE(0)) dut (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_mask(host_mask),
    .host_ready(host_ready), .host_done(host_done), .host_rdata(host_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce(mem_ce),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  // Small RAM model indexed by the low address bits.
  logic [15:0] ram [0:63];
  logic        sel, ram_rd;
  assign sel    = !mem_ce_n && mem_ce;
  assign ram_rd = sel && !mem_oe_n && mem_we_n;

  always_comb begin
    mem_dq_in = '0;
    for (int i = 0; i < 2; i++) begin
      if (ram_rd && !mem_bs_n[i]) mem_dq_in[i*8 +: 8] = ram[mem_addr[5:0]][i*8 +: 8];
      if (mem_dq_oe[i]) mem_dq_in[i*8 +: 8] = mem_dq_in[i*8 +: 8] | mem_dq_out[i*8 +: 8];
    end
  end

  int n_checks = 0, n_fail = 0;
  int oe_run = 0, we_run = 0, last_oe = 0, last_we = 0;
  int since_oe = 1000, last_gap = 1000, done_cnt = 0, ce_cycles = 0;
  int bad_standby = 0, bad_lane = 0, bad_oe_wr = 0, bad_mask = 0;
  logic drv_prev = 1'b0;
  logic [1:0] cur_mask = 2'b11;
  bit finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) ce_cycles++;
      if (!mem_oe_n) oe_run++; else begin if (oe_run != 0) last_oe = oe_run; oe_run = 0; end
      if (!mem_we_n) we_run++; else begin if (we_run != 0) last_we = we_run; we_run = 0; end
      if (!mem_oe_n) since_oe = 0; else if (since_oe < 1000) since_oe++;
      if ((|mem_dq_oe) && !drv_prev) last_gap = since_oe;
      drv_prev = |mem_dq_oe;
      if (!mem_we_n && !mem_oe_n) bad_oe_wr++;
      if (host_ready && !(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && mem_bs_n == 2'b11))
        bad_standby++;
      if (!mem_ce_n && mem_bs_n != ~cur_mask) bad_mask++;
      for (int i = 0; i < 2; i++) if (mem_dq_oe[i] && mem_bs_n[i]) bad_lane++;
      if (host_done) done_cnt++;
      if (sel && !mem_we_n)
        for (int i = 0; i < 2; i++)
          if (!mem_bs_n[i] && mem_dq_oe[i]) ram[mem_addr[5:0]][i*8 +: 8] = mem_dq_out[i*8 +: 8];
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] m, output logic [15:0] rd, output int lat);
    int guard = 0;
    while (!host_ready && guard < 200) begin @(negedge clk); guard++; end
    cur_mask = m;
    host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d; host_mask = m;
    @(negedge clk);
    host_req = 1'b0;
    lat = 1;
    while (!host_done && lat < 200) begin @(negedge clk); lat++; end
    rd = host_rdata;
    @(negedge clk);
    chk(!host_done, "R8 done single cycle", host_done, 0);
  endtask

  task automatic t_reset();
    chk(host_ready && !host_done, "R1 host side", {host_ready, host_done}, 2'b10);
    chk(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n, "R1 controls",
        {mem_ce_n, mem_ce, mem_oe_n, mem_we_n}, 4'b1011);
    chk(mem_bs_n == 2'b11 && mem_dq_oe == 2'b00, "R1 lanes", {mem_bs_n, mem_dq_oe}, 4'b1100);
  endtask

  task automatic t_full_word();
    logic [15:0] rd; int lat;
    access(1'b1, 19'h40005, 16'h1234, 2'b11, rd, lat);
    chk(lat == T_WP + 1, "R3 write latency", lat, T_WP + 1);
    chk(last_we == T_WP, "R3 write pulse", last_we, T_WP);
    chk(bad_oe_wr == 0, "R3 oe high in write", bad_oe_wr, 0);
    access(1'b0, 19'h40005, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'h1234, "R2 read data", rd, 16'h1234);
    chk(last_oe == T_RD, "R2 oe low width", last_oe, T_RD);
    chk(lat == T_RD + 1, "R2 read latency", lat, T_RD + 1);
  endtask

  task automatic t_lanes();
    logic [15:0] rd; int lat;
    access(1'b1, 19'h6, 16'hABCD, 2'b11, rd, lat);
    access(1'b1, 19'h6, 16'hEE11, 2'b01, rd, lat);
    access(1'b0, 19'h6, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'hAB11, "R4 low lane write", rd, 16'hAB11);
    access(1'b1, 19'h6, 16'h77EE, 2'b10, rd, lat);
    access(1'b0, 19'h6, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'h7711, "R4 high lane write", rd, 16'h7711);
    access(1'b0, 19'h6, 16'h0, 2'b01, rd, lat);
    chk(rd == 16'h0011, "R4 low lane read", rd, 16'h0011);
    access(1'b0, 19'h6, 16'h0, 2'b10, rd, lat);
    chk(rd == 16'h7700, "R4 high lane read", rd, 16'h7700);
    chk(bad_lane == 0 && bad_mask == 0, "R4 strobes follow mask", bad_lane + bad_mask, 0);
  endtask

  task automatic t_zero_mask();
    logic [15:0] rd; int lat; int ce0;
    ce0 = ce_cycles;
    access(1'b1, 19'h6, 16'hFFFF, 2'b00, rd, lat);
    chk(lat == 1, "R7 zero mask latency", lat, 1);
    chk(ce_cycles == ce0, "R7 no memory cycle", ce_cycles - ce0, 0);
    access(1'b0, 19'h6, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'h7711, "R7 memory unchanged", rd, 16'h7711);
  endtask

  task automatic t_turnaround();
    logic [15:0] rd; int lat;
    access(1'b0, 19'h40005, 16'h0, 2'b11, rd, lat);
    access(1'b1, 19'h7, 16'h5A5A, 2'b11, rd, lat);
    chk(last_gap >= T_TRN, "R6 turnaround gap", last_gap, T_TRN);
    access(1'b0, 19'h7, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'h5A5A, "R6 write after read data", rd, 16'h5A5A);
  endtask

  task automatic t_busy_request();
    logic [15:0] rd; int lat; int d0;
    while (!host_ready) @(negedge clk);
    d0 = done_cnt;
    cur_mask = 2'b11;
    host_req = 1'b1; host_wr = 1'b0; host_addr = 19'h40005; host_mask = 2'b11;
    @(negedge clk);
    host_req = 1'b0;
    repeat (3) @(negedge clk);
    chk(!host_ready, "R8 busy not ready", host_ready, 0);
    host_req = 1'b1; host_wr = 1'b1; host_addr = 19'h8; host_wdata = 16'hDEAD;
    repeat (T_RD + 2) @(negedge clk);   // held across the read end and into turnaround
    host_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(done_cnt - d0 == 1, "R8 one done per request", done_cnt - d0, 1);
    chk(host_rdata == 16'h1234, "R8 read intact", host_rdata, 16'h1234);
    access(1'b0, 19'h8, 16'h0, 2'b11, rd, lat);
    chk(rd == 16'h1008, "R8 ignored write", rd, 16'h1008);
    chk(bad_standby == 0, "R5 standby while ready", bad_standby, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ram[i] = 16'h1000 + 16'(i);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_word();
    t_lanes();
    t_zero_mask();
    t_turnaround();
    t_busy_request();
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule